// File: doc/BRIEF.md
# Paired peripheral DMA channel

This block moves data between one serial peripheral and system memory without processor help. It has two fixed channels: a receive channel and a transmit channel. Receive moves each word that the peripheral has captured into memory. Transmit fetches each word from memory and hands it to the peripheral's transmit register. Every move is started by a ready strobe from the peripheral and never by software.

Each channel holds a current memory pointer with its item count, and a second "next" pointer and count. When the current buffer runs out and a next buffer is programmed, the next buffer becomes current on the same clock edge. Software can therefore queue a second buffer while the first one is still in progress.

Software programs the channels through a small register window. It reads per-direction status flags there, and four interrupt lines report when a direction has finished its work. Memory is reached through a single-word request/grant port. Only one access is in flight at a time.

Top module: `pdma_pair`

## Requirements
- R1: After reset every pointer, count and next count reads zero, the control register reads zero, `mem_req` is low, the status register reads 0xF and all four interrupt outputs are low.
- R2: The register window sits at byte offsets 0x100 to 0x124. Receive uses current pointer 0x100, current count 0x104, next pointer 0x108 and next count 0x10C. Transmit uses the same four registers at 0x110, 0x114, 0x118 and 0x11C. Control is at 0x120 and status at 0x124. Pointers read back as written. Counts keep only their low 16 bits and read back zero-extended.
- R3: An accepted receive strobe captures `rx_data`. One write of that word is then made to memory at the receive pointer, and `rx_ack` pulses for one cycle in the cycle after the grant.
- R4: An accepted transmit strobe reads memory at the transmit pointer. In the cycle after the grant the returned word appears on `tx_data` and `tx_load` pulses for one cycle.
- R5: Each completed item advances the channel's pointer by the item size and lowers its count by one. `item_size` 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes.
- R6: A channel chains to its next buffer in two cases. If a completed item brings the current count to zero while the next count is nonzero, the next pointer and next count become current on that same edge and the next count is cleared. If the current count is already zero when a nonzero next count is written, the same load happens on the following edge.
- R7: Status bit 0 (receive) and bit 1 (transmit) are set while that direction's current count is zero. Bit 2 (receive) and bit 3 (transmit) are set while both its current and next counts are zero. Each interrupt output is the matching flag ANDed with that direction's enable. The end interrupt rises in the first cycle after the grant of the final item.
- R8: Control bit 0 enables receive and bit 1 enables transmit. A strobe is ignored, and no memory access follows from it, when its channel is disabled, when its current count is zero, or when a move is already pending on that channel.
- R9: When receive and transmit moves are pending in the same cycle, receive is granted the memory port first.
- R10: Only one memory access is outstanding. `mem_req` stays high with a stable `mem_addr` until `mem_gnt`, and it is low in the cycle after each grant.
- R11: Writing a nonzero current count clears that direction's end flag and buffer flag from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register access select |
| reg_we | input | 1 | Register write enable (with reg_sel) |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational, zero when not selected) |
| item_size | input | 2 | Item size code for pointer advance |
| rx_ready | input | 1 | Peripheral has a received word |
| rx_data | input | 32 | Received word from the peripheral |
| rx_ack | output | 1 | One-cycle pulse: received word stored |
| tx_ready | input | 1 | Peripheral transmit register is empty |
| tx_data | output | 32 | Word for the peripheral transmit register |
| tx_load | output | 1 | One-cycle pulse: tx_data is valid to load |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_gnt |
| mem_gnt | input | 1 | Memory access completes this cycle |
| irq_rx_end | output | 1 | Receive current count is zero (when enabled) |
| irq_rx_full | output | 1 | Receive current and next counts are zero (when enabled) |
| irq_tx_end | output | 1 | Transmit current count is zero (when enabled) |
| irq_tx_empty | output | 1 | Transmit current and next counts are zero (when enabled) |

## Verification
The receive path is driven with a table of size codes, start counts and strobe numbers. This separates a 1-, 2- or 4-byte step from a wrong step, and shows that strobes beyond the programmed count leave the pointer and count where they are. Directed cases chain from a current buffer to a next buffer, both on the last item and through a software write while the count is zero. They show that the next registers are copied and the next count is cleared, rather than the old pointer simply advancing. Cycle-exact sampling around the final grant tells an end interrupt on the right edge apart from one that is a cycle early or late. Simultaneous receive and transmit strobes show which direction wins the port. A strobe to a disabled channel must produce no request at all.

// File: rtl/pdma_pkg.sv
// Shared constants and helpers for the paired peripheral DMA block.
// Assumes exactly two channels: index 0 receive, index 1 transmit.
package pdma_pkg;

    typedef enum logic {
        CH_RX = 1'b0,
        CH_TX = 1'b1
    } chan_e;

    localparam int NUM_CH       = 2;
    localparam int SLOTS_PER_CH = 4;
    localparam int SLOT_PTR     = 0;
    localparam int SLOT_CNT     = 1;
    localparam int SLOT_NPTR    = 2;
    localparam int SLOT_NCNT    = 3;
    localparam int SLOT_CTRL    = NUM_CH * SLOTS_PER_CH;
    localparam int SLOT_STAT    = SLOT_CTRL + 1;
    localparam int NUM_SLOTS    = SLOT_STAT + 1;

    // Byte step for one item: code 0 -> 1, code 1 -> 2, otherwise 4.
    function automatic logic [2:0] item_step(input logic [1:0] code);
        case (code)
            2'd0:    item_step = 3'd1;
            2'd1:    item_step = 3'd2;
            default: item_step = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/pdma_chan.sv
// One DMA direction: current and next pointer/count, strobe acceptance,
// pointer advance and automatic chaining to the next buffer.
// Assumes the arbiter raises done only while it serves this channel and
// that software does not rewrite the current pointer while a move is active.
module pdma_chan
    import pdma_pkg::*;
#(
    parameter int PTR_W = 32,
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    strobe,
    input  logic                    busy,
    input  logic                    done,
    input  logic [1:0]              item_size,
    input  logic [SLOTS_PER_CH-1:0] wr_slot,
    input  logic [PTR_W-1:0]        wdata,
    output logic [PTR_W-1:0]        cur_ptr,
    output logic [CNT_W-1:0]        cur_cnt,
    output logic [PTR_W-1:0]        nxt_ptr,
    output logic [CNT_W-1:0]        nxt_cnt,
    output logic                    pend,
    output logic                    accept,
    output logic                    flag_end,
    output logic                    flag_buf
);

    logic             last_item;
    logic             chain_done;
    logic             idle_chain;
    logic [PTR_W-1:0] step_ptr;

    assign last_item  = done && (cur_cnt == CNT_W'(1));
    assign chain_done = last_item && (nxt_cnt != '0);
    assign idle_chain = !done && (cur_cnt == '0) && (nxt_cnt != '0);
    assign step_ptr   = cur_ptr + PTR_W'(item_step(item_size));
    assign accept     = strobe && en && (cur_cnt != '0) && !pend;
    assign flag_end   = (cur_cnt == '0);
    assign flag_buf   = (cur_cnt == '0) && (nxt_cnt == '0);

    // Pending move: set on an accepted strobe, cleared on completion or disable.
    always_ff @(posedge clk) begin
        if (!rst_n)            pend <= 1'b0;
        else if (done)         pend <= 1'b0;
        else if (accept)       pend <= 1'b1;
        else if (!en && !busy) pend <= 1'b0;
    end

    // Current pointer: software write, chain load or item advance.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cur_ptr <= '0;
        else if (wr_slot[SLOT_PTR])         cur_ptr <= wdata;
        else if (chain_done || idle_chain)  cur_ptr <= nxt_ptr;
        else if (done)                      cur_ptr <= step_ptr;
    end

    // Current count: software write, chain load or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cur_cnt <= '0;
        else if (wr_slot[SLOT_CNT])         cur_cnt <= wdata[CNT_W-1:0];
        else if (chain_done || idle_chain)  cur_cnt <= nxt_cnt;
        else if (done)                      cur_cnt <= cur_cnt - CNT_W'(1);
    end

    // Next pointer: written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n)                  nxt_ptr <= '0;
        else if (wr_slot[SLOT_NPTR]) nxt_ptr <= wdata;
    end

    // Next count: written by software, cleared once it has been chained.
    always_ff @(posedge clk) begin
        if (!rst_n)                         nxt_count_reset();
        else if (wr_slot[SLOT_NCNT])        nxt_cnt <= wdata[CNT_W-1:0];
        else if (chain_done || idle_chain)  nxt_cnt <= '0;
    end

    task automatic nxt_count_reset();
        nxt_cnt <= '0;
    endtask

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !chain_done && (wr_slot == '0))
        |=> (cur_cnt == $past(cur_cnt) - CNT_W'(1)));

    // R6
    chain_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cur_cnt == CNT_W'(1)) && (nxt_cnt != '0) && (wr_slot == '0))
        |=> ((cur_ptr == $past(nxt_ptr)) && (cur_cnt == $past(nxt_cnt)) && (nxt_cnt == '0)));

    // R8
    idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !pend) |=> !pend);

    // R8
    no_empty_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cur_cnt != '0));

endmodule

// File: rtl/pdma_regs.sv
// Software register window: address decode, write strobes per channel
// register, the enable control register and the combinational read mux.
// Assumes word-aligned accesses; unmatched addresses read zero.
module pdma_regs
    import pdma_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int          DATA_W   = 32,
    parameter int          PTR_W    = 32,
    parameter int          CNT_W    = 16,
    parameter logic [31:0] WIN_BASE = 32'h100
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   reg_sel,
    input  logic                                   reg_we,
    input  logic [ADDR_W-1:0]                      reg_addr,
    input  logic [NUM_CH-1:0]                      ctrl_wdata,
    output logic [DATA_W-1:0]                      reg_rdata,
    input  logic [NUM_CH-1:0][PTR_W-1:0]           ch_ptr,
    input  logic [NUM_CH-1:0][CNT_W-1:0]           ch_cnt,
    input  logic [NUM_CH-1:0][PTR_W-1:0]           ch_nptr,
    input  logic [NUM_CH-1:0][CNT_W-1:0]           ch_ncnt,
    input  logic [NUM_CH-1:0]                      ch_end,
    input  logic [NUM_CH-1:0]                      ch_buf,
    output logic [NUM_CH-1:0]                      ch_en,
    output logic [NUM_CH-1:0][SLOTS_PER_CH-1:0]    wr_slot
);

    logic [NUM_SLOTS-1:0] slot_hit;

    // One address comparator per register slot.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_hit
        assign slot_hit[s] = reg_sel && (reg_addr == ADDR_W'(WIN_BASE + 32'(4 * s)));
    end

    // Per-channel write strobes.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_wr
        for (genvar k = 0; k < SLOTS_PER_CH; k++) begin : g_slot
            assign wr_slot[c][k] = reg_we && slot_hit[c * SLOTS_PER_CH + k];
        end
    end

    // Control register holding the channel enables.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ch_en <= '0;
        else if (reg_we && slot_hit[SLOT_CTRL]) ch_en <= ctrl_wdata;
    end

    // Read mux over all slots.
    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (slot_hit[c * SLOTS_PER_CH + SLOT_PTR])  reg_rdata = DATA_W'(ch_ptr[c]);
            if (slot_hit[c * SLOTS_PER_CH + SLOT_CNT])  reg_rdata = DATA_W'(ch_cnt[c]);
            if (slot_hit[c * SLOTS_PER_CH + SLOT_NPTR]) reg_rdata = DATA_W'(ch_nptr[c]);
            if (slot_hit[c * SLOTS_PER_CH + SLOT_NCNT]) reg_rdata = DATA_W'(ch_ncnt[c]);
        end
        if (slot_hit[SLOT_CTRL]) reg_rdata = DATA_W'(ch_en);
        if (slot_hit[SLOT_STAT]) reg_rdata = DATA_W'({ch_buf, ch_end});
    end

    // R2
    one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_hit));

endmodule

// File: rtl/pdma_arb.sv
// Memory port sequencer: picks one pending channel (receive first), holds
// the request until granted, then reports completion to that channel.
// Assumes mem_gnt is only raised while mem_req is high.
module pdma_arb
    import pdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pend,
    input  logic              mem_gnt,
    output logic              mem_req,
    output chan_e             sel,
    output logic [NUM_CH-1:0] done,
    output logic [NUM_CH-1:0] busy_ch
);

    logic busy_q;

    assign mem_req = busy_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_stat
        assign busy_ch[c] = busy_q && (sel == chan_e'(c));
        assign done[c]    = busy_ch[c] && mem_gnt;
    end

    // Start a move when idle, finish it on the grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sel    <= CH_RX;
        end else if (!busy_q) begin
            if (pend[CH_RX]) begin
                busy_q <= 1'b1;
                sel    <= CH_RX;
            end else if (pend[CH_TX]) begin
                busy_q <= 1'b1;
                sel    <= CH_TX;
            end
        end else if (mem_gnt) begin
            busy_q <= 1'b0;
        end
    end

    // R9
    rx_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && pend[CH_RX] && pend[CH_TX]) |=> (mem_req && (sel == CH_RX)));

    // R10
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(sel)));

    // R10
    gap_after_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_gnt |=> !mem_req);

endmodule

// File: rtl/pdma_pair.sv
// Top of the paired peripheral DMA block: one receive and one transmit
// channel sharing a single-word memory port and a register window.
// Assumes the peripheral holds rx_data stable for the strobe cycle and
// that the memory returns read data together with mem_gnt.
module pdma_pair
    import pdma_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int          DATA_W   = 32,
    parameter int          PTR_W    = 32,
    parameter int          CNT_W    = 16,
    parameter logic [31:0] WIN_BASE = 32'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [1:0]        item_size,
    input  logic              rx_ready,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ack,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_load,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_gnt,
    output logic              irq_rx_end,
    output logic              irq_rx_full,
    output logic              irq_tx_end,
    output logic              irq_tx_empty
);

    logic [NUM_CH-1:0][PTR_W-1:0]        ch_ptr;
    logic [NUM_CH-1:0][PTR_W-1:0]        ch_nptr;
    logic [NUM_CH-1:0][CNT_W-1:0]        ch_cnt;
    logic [NUM_CH-1:0][CNT_W-1:0]        ch_ncnt;
    logic [NUM_CH-1:0][SLOTS_PER_CH-1:0] wr_slot;
    logic [NUM_CH-1:0]                   ch_en;
    logic [NUM_CH-1:0]                   ch_end;
    logic [NUM_CH-1:0]                   ch_buf;
    logic [NUM_CH-1:0]                   ch_pend;
    logic [NUM_CH-1:0]                   ch_accept;
    logic [NUM_CH-1:0]                   ch_done;
    logic [NUM_CH-1:0]                   ch_busy;
    logic [NUM_CH-1:0]                   strobe;
    chan_e                               arb_sel;
    logic [DATA_W-1:0]                   rx_hold;

    assign strobe = {tx_ready, rx_ready};

    pdma_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W),
        .CNT_W(CNT_W), .WIN_BASE(WIN_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
        .ctrl_wdata(reg_wdata[NUM_CH-1:0]), .reg_rdata(reg_rdata),
        .ch_ptr(ch_ptr), .ch_cnt(ch_cnt), .ch_nptr(ch_nptr), .ch_ncnt(ch_ncnt),
        .ch_end(ch_end), .ch_buf(ch_buf), .ch_en(ch_en), .wr_slot(wr_slot)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pdma_chan #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .en(ch_en[c]), .strobe(strobe[c]),
            .busy(ch_busy[c]), .done(ch_done[c]),
            .item_size(item_size), .wr_slot(wr_slot[c]),
            .wdata(reg_wdata[PTR_W-1:0]),
            .cur_ptr(ch_ptr[c]), .cur_cnt(ch_cnt[c]),
            .nxt_ptr(ch_nptr[c]), .nxt_cnt(ch_ncnt[c]),
            .pend(ch_pend[c]), .accept(ch_accept[c]),
            .flag_end(ch_end[c]), .flag_buf(ch_buf[c])
        );
    end

    pdma_arb u_arb (
        .clk(clk), .rst_n(rst_n),
        .pend(ch_pend), .mem_gnt(mem_gnt),
        .mem_req(mem_req), .sel(arb_sel),
        .done(ch_done), .busy_ch(ch_busy)
    );

    assign mem_addr  = ch_ptr[arb_sel];
    assign mem_we    = mem_req && (arb_sel == CH_RX);
    assign mem_wdata = rx_hold;

    assign irq_rx_end   = ch_end[CH_RX] && ch_en[CH_RX];
    assign irq_rx_full  = ch_buf[CH_RX] && ch_en[CH_RX];
    assign irq_tx_end   = ch_end[CH_TX] && ch_en[CH_TX];
    assign irq_tx_empty = ch_buf[CH_TX] && ch_en[CH_TX];

    // Capture the received word when the receive channel accepts a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rx_hold <= '0;
        else if (ch_accept[CH_RX])  rx_hold <= rx_data;
    end

    // Completion pulses and the transmit data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ack  <= 1'b0;
            tx_load <= 1'b0;
            tx_data <= '0;
        end else begin
            rx_ack  <= ch_done[CH_RX];
            tx_load <= ch_done[CH_TX];
            if (ch_done[CH_TX]) tx_data <= mem_rdata;
        end
    end

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> $stable(mem_addr));

    // R3
    ack_after_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ack |-> $past(mem_gnt && mem_we));

endmodule

// File: tb/sim_pdma_pair.sv
`timescale 1ns/1ps
module sim_pdma_pair;

    localparam logic [11:0] A_RX_PTR  = 12'h100;
    localparam logic [11:0] A_RX_CNT  = 12'h104;
    localparam logic [11:0] A_RX_NPTR = 12'h108;
    localparam logic [11:0] A_RX_NCNT = 12'h10C;
    localparam logic [11:0] A_TX_PTR  = 12'h110;
    localparam logic [11:0] A_TX_CNT  = 12'h114;
    localparam logic [11:0] A_TX_NPTR = 12'h118;
    localparam logic [11:0] A_TX_NCNT = 12'h11C;
    localparam logic [11:0] A_CTRL    = 12'h120;
    localparam logic [11:0] A_STAT    = 12'h124;

    // {size, start count, strobes, expected pointer delta, expected count}
    localparam int NVEC = 5;
    localparam logic [57:0] VEC [NVEC] = '{
        {2'd0, 16'd5, 8'd3, 16'd3, 16'd2},
        {2'd1, 16'd4, 8'd4, 16'd8, 16'd0},
        {2'd2, 16'd6, 8'd2, 16'd8, 16'd4},
        {2'd3, 16'd3, 8'd1, 16'd4, 16'd2},
        {2'd2, 16'd2, 8'd5, 16'd8, 16'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [1:0]  item_size = 2'd2;
    logic        rx_ready = 1'b0, tx_ready = 1'b0;
    logic [31:0] rx_data = '0, tx_data;
    logic        rx_ack, tx_load;
    logic        mem_req, mem_we, mem_gnt = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        irq_rx_end, irq_rx_full, irq_tx_end, irq_tx_empty;

    logic [31:0] mem [256];
    int checks = 0;
    int failures = 0;
    int port_err = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pdma_pair u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .item_size(item_size),
        .rx_ready(rx_ready), .rx_data(rx_data), .rx_ack(rx_ack),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_load(tx_load),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt),
        .irq_rx_end(irq_rx_end), .irq_rx_full(irq_rx_full),
        .irq_tx_end(irq_tx_end), .irq_tx_empty(irq_tx_empty)
    );

    // Memory model: grant one cycle after a request, word indexed by addr[9:2].
    assign mem_rdata = mem[mem_addr[9:2]];
    always @(posedge clk) begin
        mem_gnt <= mem_req && !mem_gnt;
        if (mem_gnt && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end

    // R10 port monitor: request held with stable address, gap after grant.
    logic        p_req = 1'b0, p_gnt = 1'b0;
    logic [31:0] p_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_req && !p_gnt && (!mem_req || mem_addr != p_addr)) port_err++;
            if (p_gnt && mem_req) port_err++;
        end
        p_req  <= mem_req;
        p_gnt  <= mem_gnt;
        p_addr <= mem_addr;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_sel = 1'b0;
    endtask

    task automatic pulse_rx(input logic [31:0] d);
        @(negedge clk);
        rx_ready = 1'b1; rx_data = d;
        @(negedge clk);
        rx_ready = 1'b0;
    endtask

    task automatic pulse_tx();
        @(negedge clk);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic wait_for_gnt();
        bit found = 0;
        for (int k = 0; k < 12 && !found; k++) begin
            if (mem_gnt) found = 1;
            else @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        bit saw;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(A_RX_PTR, v);  check("R1 rx ptr", v, 32'h0);
        reg_read(A_TX_NCNT, v); check("R1 tx next cnt", v, 32'h0);
        reg_read(A_CTRL, v);    check("R1 ctrl", v, 32'h0);
        reg_read(A_STAT, v);    check("R1 status", v, 32'hF);
        check("R1 irqs", {28'h0, irq_rx_end, irq_rx_full, irq_tx_end, irq_tx_empty}, 32'h0);
        check("R1 mem_req", {31'h0, mem_req}, 32'h0);

        // R5 R8 table of size / count / strobe vectors on the receive channel
        for (int n = 0; n < NVEC; n++) begin
            reg_write(A_CTRL, 32'h0);
            item_size = VEC[n][57:56];
            reg_write(A_RX_PTR, 32'h1000);
            reg_write(A_RX_CNT, {16'h0, VEC[n][55:40]});
            reg_write(A_CTRL, 32'h1);
            for (int s = 0; s < int'(VEC[n][39:32]); s++) begin
                pulse_rx(32'h100 + 32'(s));
                repeat (8) @(negedge clk);
            end
            reg_read(A_RX_PTR, v); check("R5 vector pointer", v, 32'h1000 + {16'h0, VEC[n][31:16]});
            reg_read(A_RX_CNT, v); check("R5/R8 vector count", v, {16'h0, VEC[n][15:0]});
        end

        // R2 register window read-back and count truncation
        reg_write(A_TX_NPTR, 32'hDEADBEEC);
        reg_read(A_TX_NPTR, v); check("R2 tx next ptr", v, 32'hDEADBEEC);
        reg_write(A_RX_NCNT, 32'h0);
        reg_write(A_TX_NCNT, 32'h0);
        reg_write(A_TX_CNT, 32'h0001_2345);
        reg_read(A_TX_CNT, v); check("R2 count truncation", v, 32'h2345);
        reg_write(A_TX_CNT, 32'h0);

        // R3 received words land in memory at the pointer
        item_size = 2'd2;
        reg_write(A_RX_PTR, 32'h40);
        reg_write(A_RX_CNT, 32'd2);
        reg_write(A_CTRL, 32'h1);
        pulse_rx(32'hA5A50001); repeat (8) @(negedge clk);
        pulse_rx(32'hA5A50002); repeat (8) @(negedge clk);
        check("R3 first word", mem[8'h10], 32'hA5A50001);
        check("R3 second word", mem[8'h11], 32'hA5A50002);

        // R6 chaining on the last item
        reg_write(A_RX_PTR, 32'h80);
        reg_write(A_RX_CNT, 32'd1);
        reg_write(A_RX_NPTR, 32'h200);
        reg_write(A_RX_NCNT, 32'd3);
        pulse_rx(32'h77); repeat (8) @(negedge clk);
        check("R6 chained word", mem[8'h20], 32'h77);
        reg_read(A_RX_PTR, v);  check("R6 chained ptr", v, 32'h200);
        reg_read(A_RX_CNT, v);  check("R6 chained cnt", v, 32'd3);
        reg_read(A_RX_NCNT, v); check("R6 next cnt cleared", v, 32'd0);
        pulse_rx(32'h78); repeat (8) @(negedge clk);
        reg_read(A_RX_PTR, v);  check("R5 ptr after chain", v, 32'h204);
        reg_read(A_RX_CNT, v);  check("R5 cnt after chain", v, 32'd2);

        // R11 R7 end flag cleared by a nonzero count, interrupt edge timing
        reg_write(A_RX_PTR, 32'h300);
        reg_write(A_RX_CNT, 32'd1);
        reg_read(A_STAT, v); check("R11 rx flags cleared", v & 32'h5, 32'h0);
        pulse_rx(32'h55);
        wait_for_gnt();
        check("R7 irq low at grant", {31'h0, irq_rx_end}, 32'h0);
        @(negedge clk);
        check("R7 irq high after grant", {31'h0, irq_rx_end}, 32'h1);
        check("R3 rx_ack pulse", {31'h0, rx_ack}, 32'h1);
        check("R7 rx full irq", {31'h0, irq_rx_full}, 32'h1);
        @(negedge clk);
        check("R3 rx_ack single cycle", {31'h0, rx_ack}, 32'h0);

        // R8 disabled transmit ignores its strobe
        reg_write(A_CTRL, 32'h0);
        reg_write(A_TX_PTR, 32'hC0);
        reg_write(A_TX_CNT, 32'd3);
        pulse_tx();
        saw = 0;
        for (int k = 0; k < 10; k++) begin
            if (mem_req) saw = 1;
            @(negedge clk);
        end
        check("R8 no request when disabled", {31'h0, saw}, 32'h0);
        reg_read(A_TX_CNT, v); check("R8 count unchanged", v, 32'd3);

        // R4 transmit fetch
        mem[8'h30] = 32'hCAFE0001;
        mem[8'h31] = 32'hCAFE0002;
        reg_write(A_CTRL, 32'h2);
        pulse_tx();
        saw = 0;
        for (int k = 0; k < 12 && !saw; k++) begin
            if (tx_load) saw = 1;
            else @(negedge clk);
        end
        check("R4 tx_load seen", {31'h0, saw}, 32'h1);
        check("R4 tx_data", tx_data, 32'hCAFE0001);
        reg_read(A_TX_PTR, v); check("R4 tx ptr", v, 32'hC4);
        reg_read(A_TX_CNT, v); check("R4 tx cnt", v, 32'd2);

        // R9 simultaneous strobes: receive first
        reg_write(A_RX_PTR, 32'h100);
        reg_write(A_RX_CNT, 32'd1);
        reg_write(A_CTRL, 32'h3);
        @(negedge clk);
        rx_ready = 1'b1; tx_ready = 1'b1; rx_data = 32'h99;
        @(negedge clk);
        rx_ready = 1'b0; tx_ready = 1'b0;
        saw = 0;
        for (int k = 0; k < 12 && !saw; k++) begin
            if (mem_req) saw = 1;
            else @(negedge clk);
        end
        check("R9 first access is a write", {31'h0, mem_we}, 32'h1);
        check("R9 first address", mem_addr, 32'h100);
        repeat (12) @(negedge clk);
        check("R9 tx served after", tx_data, 32'hCAFE0002);
        reg_read(A_TX_CNT, v); check("R9 tx cnt", v, 32'd1);

        // R6 chaining by software while the current count is zero
        reg_write(A_CTRL, 32'h0);
        reg_write(A_RX_NPTR, 32'h500);
        reg_write(A_RX_NCNT, 32'd4);
        repeat (2) @(negedge clk);
        reg_read(A_RX_PTR, v);  check("R6 idle chain ptr", v, 32'h500);
        reg_read(A_RX_CNT, v);  check("R6 idle chain cnt", v, 32'd4);
        reg_read(A_RX_NCNT, v); check("R6 idle chain next cleared", v, 32'd0);

        // R10 port discipline over the whole run
        check("R10 request/grant discipline", 32'(port_err), 32'h0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule